// File: doc/BRIEF.md
# Loop Sequencer with Three-Array Address Generator

This block is the control half of a loop accelerator that stands in for a software inner loop. Software loads an iteration bound and up to three array descriptors (a base address, a signed stride and an enable), then writes a start bit and lets the processor sleep. The block then runs the loop with no software involvement. In every iteration it issues one memory read for each enabled array, strictly one after another. It places each returned word in the fabric input register that belongs to that array. When all reads of the iteration are back, it strobes the fabric for one cycle.

The loop ends after the programmed number of iterations. It also ends early when the datapath raises its exit condition during an iteration's strobe cycle. In both cases the current iteration finishes and no further reads are issued. At the end the block raises a sticky interrupt, which software clears by writing a one. A status word gives the busy flag, the interrupt, the reason for the exit, and the count of completed iterations. All memory traffic of the accelerator passes through this block, and the fabric never drives an address itself.

Top module: `loop_agu`

## Requirements
- R1: After reset the block is idle: no memory request, no fabric strobe, interrupt low, and the status word (word 0), bound (word 1) and iteration count (word 2) all read zero.
- R2: In iteration i (counting from 0) the read for array k uses address base_k + i * stride_k, modulo 2^32. The stride is the signed 16-bit field in bits 15:0 of the array's descriptor word. The base lives at word 4+2k and the descriptor at word 5+2k.
- R3: Within an iteration, reads go out in the order array 0, 1, 2. Arrays whose enable (descriptor bit 16) is clear are skipped. A request that is stalled by a low ready keeps its valid and its address unchanged. After a request is accepted, no new request is issued until its response has arrived.
- R4: The response to the read of array k is loaded into fabric register k (fabData0/1/2). The fabric register of a disabled array keeps its previous value.
- R5: fabValid is high for one cycle per iteration, after all enabled reads of that iteration have returned. If no array is enabled, every iteration is a single strobe cycle.
- R6: A run performs exactly the number of iterations held in the bound register (word 1, 16 bits). A bound of zero ends the run at once, with zero iterations and no requests.
- R7: exitCond is sampled only in an iteration's strobe cycle. When it is high there and the iteration is not the last one, the run ends after that iteration with no further requests, and the status exit-cause bit (bit 2) reads 1. If the last iteration is reached, the bound takes precedence and the cause reads 0.
- R8: Word 2 reads the number of completed iterations of the latest run. Status bit 0 is high while a run is in progress.
- R9: doneIrq (also status bit 1) rises when a run ends. It stays high until a write to word 0 with bit 1 set.
- R10: Writing the start bit (word 0, bit 0) while a run is in progress has no effect: the run continues with its iteration count and its address sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration word index |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read data (combinational from cfgAddr) |
| memReqValid | output | 1 | Read request valid |
| memReqAddr | output | 32 | Read request address |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | 32 | Read response data |
| fabData0 | output | 32 | Fabric input register for array 0 |
| fabData1 | output | 32 | Fabric input register for array 1 |
| fabData2 | output | 32 | Fabric input register for array 2 |
| fabValid | output | 1 | Iteration data ready strobe |
| exitCond | input | 1 | Early-exit condition from the datapath |
| doneIrq | output | 1 | Sticky completion interrupt |

## Verification
The assertions assume that memory returns exactly one response per accepted request, and never sends a response without an outstanding read. They also assume that software changes array descriptors only while the block is idle. The bench memory model holds at most one pending read and answers it after a programmable latency. It can toggle ready on alternate cycles to create stalls. Every run is configured from idle. The exit condition is derived from the bench's own count of strobes, so it is raised in a chosen iteration.

// File: rtl/loop_agu_pkg.sv
package loop_agu_pkg;
  localparam int NUM_ARR = 3;
  localparam int SEL_W   = 2;

  // Configuration word indices; array k owns words REG_ARR_BASE+2k and +2k+1.
  localparam int REG_CTRL     = 0;
  localparam int REG_BOUND    = 1;
  localparam int REG_COUNT    = 2;
  localparam int REG_ARR_BASE = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_STROBE
  } seqState_t;

  // Strobes sent from the sequencer to the datapath.
  typedef struct packed {
    logic             init;      // load pointers from bases, clear count
    logic             capture;   // response for array sel has arrived
    logic [SEL_W-1:0] sel;       // array currently addressed
    logic             iterDone;  // one iteration completed
  } ctrlStrobe_t;

  // Lowest enabled array index at or above fromIdx; MSB flags success.
  function automatic logic [SEL_W:0] pickEnabled(input logic [NUM_ARR-1:0] en,
                                                 input int fromIdx);
    logic [SEL_W:0] res;
    res = '0;
    for (int k = NUM_ARR - 1; k >= 0; k--) begin
      if (k >= fromIdx && en[k]) res = {1'b1, SEL_W'(k)};
    end
    return res;
  endfunction
endpackage

// File: rtl/loop_agu_dpath.sv
module loop_agu_dpath
  import loop_agu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ITER_W   = 16,
  parameter int STRIDE_W = 16,
  parameter int CFG_AW   = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWrEn,
  input  logic [CFG_AW-1:0]              cfgAddr,
  input  logic [ADDR_W-1:0]              cfgWrData,
  output logic [ADDR_W-1:0]              cfgRdData,
  input  logic [2:0]                     statusBits,
  input  ctrlStrobe_t                    strb,
  input  logic [DATA_W-1:0]              memRspData,
  output logic [ADDR_W-1:0]              reqAddr,
  output logic [NUM_ARR-1:0]             arrEn,
  output logic [NUM_ARR-1:0][DATA_W-1:0] fabData,
  output logic                           lastIter,
  output logic                           boundZero
);
  localparam int PAD_W = ADDR_W - STRIDE_W - 1;

  logic [ITER_W-1:0] boundR;
  logic [ITER_W-1:0] iterCount;
  logic [NUM_ARR-1:0][ADDR_W-1:0]   baseQ;
  logic [NUM_ARR-1:0][ADDR_W-1:0]   ptrQ;
  logic [NUM_ARR-1:0][STRIDE_W-1:0] strideQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      boundR    <= '0;
      iterCount <= '0;
    end else begin
      if (cfgWrEn && cfgAddr == CFG_AW'(REG_BOUND)) boundR <= cfgWrData[ITER_W-1:0];
      if (strb.init) iterCount <= '0;
      else if (strb.iterDone) iterCount <= iterCount + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_ARR; k++) begin : g_arr
    localparam logic [CFG_AW-1:0] BASE_IDX = CFG_AW'(REG_ARR_BASE + 2 * k);
    localparam logic [CFG_AW-1:0] DESC_IDX = CFG_AW'(REG_ARR_BASE + 2 * k + 1);
    logic [ADDR_W-1:0]   baseR;
    logic [ADDR_W-1:0]   ptrR;
    logic [STRIDE_W-1:0] strideR;
    logic                enR;
    logic [DATA_W-1:0]   fabR;
    logic [ADDR_W-1:0]   strideExt;

    assign strideExt = {{(ADDR_W - STRIDE_W){strideR[STRIDE_W-1]}}, strideR};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseR   <= '0;
        ptrR    <= '0;
        strideR <= '0;
        enR     <= 1'b0;
        fabR    <= '0;
      end else begin
        if (cfgWrEn && cfgAddr == BASE_IDX) baseR <= cfgWrData;
        if (cfgWrEn && cfgAddr == DESC_IDX) begin
          strideR <= cfgWrData[STRIDE_W-1:0];
          enR     <= cfgWrData[STRIDE_W];
        end
        if (strb.init) ptrR <= baseR;
        else if (strb.capture && strb.sel == SEL_W'(k)) ptrR <= ptrR + strideExt;
        if (strb.capture && strb.sel == SEL_W'(k)) fabR <= memRspData;
      end
    end

    assign baseQ[k]   = baseR;
    assign ptrQ[k]    = ptrR;
    assign strideQ[k] = strideR;
    assign arrEn[k]   = enR;
    assign fabData[k] = fabR;
  end

  assign reqAddr   = ptrQ[strb.sel];
  assign lastIter  = ({1'b0, iterCount} + 1'b1) == {1'b0, boundR};
  assign boundZero = (boundR == '0);

  always_comb begin
    cfgRdData = '0;
    if (cfgAddr == CFG_AW'(REG_CTRL)) cfgRdData = ADDR_W'(statusBits);
    else if (cfgAddr == CFG_AW'(REG_BOUND)) cfgRdData = ADDR_W'(boundR);
    else if (cfgAddr == CFG_AW'(REG_COUNT)) cfgRdData = ADDR_W'(iterCount);
    for (int k = 0; k < NUM_ARR; k++) begin
      if (cfgAddr == CFG_AW'(REG_ARR_BASE + 2 * k)) cfgRdData = baseQ[k];
      if (cfgAddr == CFG_AW'(REG_ARR_BASE + 2 * k + 1))
        cfgRdData = {{PAD_W{1'b0}}, arrEn[k], strideQ[k]};
    end
  end
endmodule

// File: rtl/loop_agu_ctrl.sv
module loop_agu_ctrl
  import loop_agu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               startWr,
  input  logic               clrIrqWr,
  input  logic [NUM_ARR-1:0] arrEn,
  input  logic               lastIter,
  input  logic               boundZero,
  input  logic               memReqReady,
  input  logic               memRspValid,
  input  logic               exitCond,
  output ctrlStrobe_t        strb,
  output logic               memReqValid,
  output logic               fabValid,
  output logic               busy,
  output logic               irq,
  output logic               exitByCond
);
  seqState_t        state, nextState;
  logic [SEL_W-1:0] selR, nextSel;
  logic [SEL_W:0]   firstPick, nextPick;
  logic             finish, finishCause;

  assign firstPick = pickEnabled(arrEn, 0);
  assign nextPick  = pickEnabled(arrEn, int'(selR) + 1);

  always_comb begin
    nextState     = state;
    nextSel       = selR;
    strb          = '0;
    strb.sel      = selR;
    memReqValid   = 1'b0;
    fabValid      = 1'b0;
    finish        = 1'b0;
    finishCause   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startWr) begin
          strb.init = 1'b1;
          if (boundZero) begin
            finish = 1'b1;
          end else if (firstPick[SEL_W]) begin
            nextState = ST_ISSUE;
            nextSel   = firstPick[SEL_W-1:0];
          end else begin
            nextState = ST_STROBE;
          end
        end
      end
      ST_ISSUE: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strb.capture = 1'b1;
          if (nextPick[SEL_W]) begin
            nextState = ST_ISSUE;
            nextSel   = nextPick[SEL_W-1:0];
          end else begin
            nextState = ST_STROBE;
          end
        end
      end
      ST_STROBE: begin
        fabValid      = 1'b1;
        strb.iterDone = 1'b1;
        if (lastIter || exitCond) begin
          finish      = 1'b1;
          finishCause = !lastIter;
          nextState   = ST_IDLE;
        end else if (firstPick[SEL_W]) begin
          nextState = ST_ISSUE;
          nextSel   = firstPick[SEL_W-1:0];
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      selR       <= '0;
      irq        <= 1'b0;
      exitByCond <= 1'b0;
    end else begin
      state <= nextState;
      selR  <= nextSel;
      if (finish) begin
        irq        <= 1'b1;
        exitByCond <= finishCause;
      end else if (clrIrqWr) begin
        irq <= 1'b0;
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/loop_agu.sv
module loop_agu
  import loop_agu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ITER_W   = 16,
  parameter int STRIDE_W = 16,
  parameter int CFG_AW   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  output logic [ADDR_W-1:0] cfgRdData,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  output logic [DATA_W-1:0] fabData0,
  output logic [DATA_W-1:0] fabData1,
  output logic [DATA_W-1:0] fabData2,
  output logic              fabValid,
  input  logic              exitCond,
  output logic              doneIrq
);
  ctrlStrobe_t                    strb;
  logic [NUM_ARR-1:0]             arrEn;
  logic [NUM_ARR-1:0][DATA_W-1:0] fabData;
  logic                           lastIter, boundZero;
  logic                           busy, exitByCond;
  logic                           ctrlWr, startWr, clrIrqWr;

  assign ctrlWr   = cfgWrEn && cfgAddr == CFG_AW'(REG_CTRL);
  assign startWr  = ctrlWr && cfgWrData[0];
  assign clrIrqWr = ctrlWr && cfgWrData[1];

  loop_agu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startWr    (startWr),
    .clrIrqWr   (clrIrqWr),
    .arrEn      (arrEn),
    .lastIter   (lastIter),
    .boundZero  (boundZero),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .exitCond   (exitCond),
    .strb       (strb),
    .memReqValid(memReqValid),
    .fabValid   (fabValid),
    .busy       (busy),
    .irq        (doneIrq),
    .exitByCond (exitByCond)
  );

  loop_agu_dpath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ITER_W  (ITER_W),
    .STRIDE_W(STRIDE_W),
    .CFG_AW  (CFG_AW)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .statusBits({exitByCond, doneIrq, busy}),
    .strb      (strb),
    .memRspData(memRspData),
    .reqAddr   (memReqAddr),
    .arrEn     (arrEn),
    .fabData   (fabData),
    .lastIter  (lastIter),
    .boundZero (boundZero)
  );

  assign fabData0 = fabData[0];
  assign fabData1 = fabData[1];
  assign fabData2 = fabData[2];
endmodule

// File: rtl/loop_agu_chk.sv
module loop_agu_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              busy,
  input logic              doneIrq,
  input logic              clrIrqWr
);
  // R3: a stalled request holds valid and address
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R3: an accepted request is not followed by another in the next cycle
  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);

  // R7: an idle sequencer issues no memory traffic
  p_idle_no_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);

  // R9: the interrupt holds until cleared
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq && !clrIrqWr |=> doneIrq);

  // R6: the interrupt only rises when the sequencer is idle
  p_irq_at_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> !busy);
endmodule

bind loop_agu loop_agu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .busy       (busy),
  .doneIrq    (doneIrq),
  .clrIrqWr   (clrIrqWr)
);

// File: tb/test_loop_agu.sv
`timescale 1ns/1ps
module test_loop_agu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memReqReady = 1'b1;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic [31:0] fabData0, fabData1, fabData2;
  logic        fabValid;
  logic        exitCond;
  logic        doneIrq;

  always #2.5 clk = ~clk;

  loop_agu i_loop_agu (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspData(memRspData), .fabData0(fabData0), .fabData1(fabData1),
    .fabData2(fabData2), .fabValid(fabValid), .exitCond(exitCond), .doneIrq(doneIrq)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // memory model and monitors
  int          latency = 0;
  logic        stallOn = 1'b0;
  logic        pend = 1'b0;
  int          waitCnt = 0;
  logic [31:0] pendAddr = '0;
  logic [31:0] reqLog [512];
  logic [31:0] fabLog [256][3];
  int          reqCount = 0;
  int          pulseCnt = 0;
  int          reqBase = 0;
  int          pulseBase = 0;
  logic        condArmed = 1'b0;
  int          condAt = 0;

  // bench view of the configuration
  logic [31:0] tbBase [3];
  logic [31:0] tbStride [3];
  logic        tbEn [3];
  logic [31:0] modelReg [3];

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic logic [31:0] expAddr(input int k, input int i);
    return tbBase[k] + 32'(i) * tbStride[k];
  endfunction

  assign exitCond = condArmed && ((pulseCnt - pulseBase) == condAt);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    memRspValid <= 1'b0;
    memReqReady <= stallOn ? ~memReqReady : 1'b1;
    if (pend) begin
      if (waitCnt == 0) begin
        memRspValid <= 1'b1;
        memRspData  <= memFn(pendAddr);
        pend        <= 1'b0;
      end else begin
        waitCnt <= waitCnt - 1;
      end
    end
    if (rstN && memReqValid && memReqReady) begin
      pend     <= 1'b1;
      pendAddr <= memReqAddr;
      waitCnt  <= latency;
      reqLog[reqCount] <= memReqAddr;
      reqCount <= reqCount + 1;
    end
    if (rstN && fabValid) begin
      fabLog[pulseCnt][0] <= fabData0;
      fabLog[pulseCnt][1] <= fabData1;
      fabLog[pulseCnt][2] <= fabData2;
      pulseCnt <= pulseCnt + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic cfgRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
  endtask

  task automatic setArray(input int k, input logic [31:0] base,
                          input logic [31:0] stride, input logic en);
    tbBase[k] = base; tbStride[k] = stride; tbEn[k] = en;
    cfgWrite(4'(4 + 2 * k), base);
    cfgWrite(4'(5 + 2 * k), {15'd0, en, stride[15:0]});
  endtask

  task automatic startRun(input int bound);
    cfgWrite(4'd0, 32'h2);
    cfgWrite(4'd1, 32'(bound));
    @(negedge clk);
    reqBase = reqCount; pulseBase = pulseCnt;
    cfgWrite(4'd0, 32'h1);
  endtask

  task automatic waitDone();
    for (int c = 0; c < 4000 && !doneIrq; c++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Compare the logged traffic of the last run against the requirements.
  task automatic verifyRun(input string tag, input int nIter, input logic expCause);
    int nEn;
    int j;
    logic [31:0] rd;
    nEn = 0;
    for (int k = 0; k < 3; k++) if (tbEn[k]) nEn++;
    chk({tag, " R6"}, "request count", 32'(reqCount - reqBase), 32'(nIter * nEn));
    chk({tag, " R5"}, "strobe count", 32'(pulseCnt - pulseBase), 32'(nIter));
    j = reqBase;
    for (int i = 0; i < nIter; i++) begin
      for (int k = 0; k < 3; k++) begin
        if (tbEn[k]) begin
          chk({tag, " R2 R3"}, $sformatf("addr it%0d arr%0d", i, k), reqLog[j], expAddr(k, i));
          j++;
        end
      end
      for (int k = 0; k < 3; k++) begin
        if (tbEn[k]) modelReg[k] = memFn(expAddr(k, i));
        chk({tag, " R4"}, $sformatf("fab it%0d reg%0d", i, k), fabLog[pulseBase + i][k], modelReg[k]);
      end
    end
    chk({tag, " R4"}, "fabData0 port", fabData0, modelReg[0]);
    chk({tag, " R4"}, "fabData1 port", fabData1, modelReg[1]);
    chk({tag, " R4"}, "fabData2 port", fabData2, modelReg[2]);
    cfgRead(4'd2, rd);
    chk({tag, " R8"}, "iteration count", rd, 32'(nIter));
    cfgRead(4'd0, rd);
    chk({tag, " R7 R9"}, "status word", rd, {29'd0, expCause, 1'b1, 1'b0});
    chk({tag, " R9"}, "doneIrq pin", 32'(doneIrq), 32'd1);
  endtask

  task automatic testReset();
    logic [31:0] rd;
    chk("R1", "memReqValid", 32'(memReqValid), 32'd0);
    chk("R1", "fabValid", 32'(fabValid), 32'd0);
    chk("R1", "doneIrq", 32'(doneIrq), 32'd0);
    cfgRead(4'd0, rd); chk("R1", "status", rd, 32'd0);
    cfgRead(4'd1, rd); chk("R1", "bound", rd, 32'd0);
    cfgRead(4'd2, rd); chk("R1", "count", rd, 32'd0);
    for (int k = 0; k < 3; k++) modelReg[k] = '0;
  endtask

  task automatic testBasic();
    setArray(0, 32'h0000_1000, 32'd4, 1'b1);
    setArray(1, 32'h0000_2000, -32'sd8, 1'b1);
    setArray(2, 32'h0000_3000, 32'd16, 1'b1);
    latency = 0; stallOn = 1'b0; condArmed = 1'b0;
    startRun(4);
    waitDone();
    verifyRun("basic", 4, 1'b0);
    repeat (10) @(negedge clk);
    chk("R9", "irq held while idle", 32'(doneIrq), 32'd1);
    cfgWrite(4'd0, 32'h2);
    @(negedge clk);
    chk("R9", "irq after clear", 32'(doneIrq), 32'd0);
  endtask

  task automatic testSkipStall();
    setArray(0, 32'hFFFF_FFF8, 32'd4, 1'b1);
    setArray(1, 32'h0000_9000, 32'd12, 1'b0);
    setArray(2, 32'h0000_5000, -32'sd2, 1'b1);
    latency = 2; stallOn = 1'b1;
    startRun(3);
    waitDone();
    verifyRun("skip", 3, 1'b0);
    stallOn = 1'b0; latency = 0;
  endtask

  task automatic testEarlyExit();
    setArray(1, 32'h0000_9000, 32'd12, 1'b1);
    condArmed = 1'b1; condAt = 2;
    startRun(10);
    waitDone();
    verifyRun("early R7", 3, 1'b1);
    condArmed = 1'b0;
  endtask

  task automatic testBoundWins();
    condArmed = 1'b1; condAt = 2;
    startRun(3);
    waitDone();
    verifyRun("bound-first R7", 3, 1'b0);
    condArmed = 1'b0;
  endtask

  task automatic testZeroBound();
    startRun(0);
    waitDone();
    verifyRun("zero R6", 0, 1'b0);
  endtask

  task automatic testNoArrays();
    setArray(0, 32'h100, 32'd4, 1'b0);
    setArray(1, 32'h200, 32'd4, 1'b0);
    setArray(2, 32'h300, 32'd4, 1'b0);
    startRun(5);
    waitDone();
    verifyRun("none R5", 5, 1'b0);
  endtask

  task automatic testRestartIgnored();
    logic [31:0] rd;
    setArray(0, 32'h0000_4000, 32'd8, 1'b1);
    setArray(1, 32'h0000_6000, 32'd4, 1'b1);
    setArray(2, 32'h0000_7000, -32'sd4, 1'b1);
    latency = 3;
    startRun(6);
    repeat (12) @(negedge clk);
    cfgRead(4'd0, rd);
    chk("R8", "busy during run", rd & 32'h1, 32'h1);
    cfgWrite(4'd0, 32'h1);
    waitDone();
    verifyRun("restart R10", 6, 1'b0);
    latency = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testSkipStall();
    testEarlyExit();
    testBoundWins();
    testZeroBound();
    testNoArrays();
    testRestartIgnored();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule